// File: doc/BRIEF.md
# Magic-Sequence Fed Watchdog Timer

This block is a watchdog peripheral on a simple single-cycle register bus. A down-counter, 24 bits wide by default, is paced by a fixed divide-by-four prescaler. It is reloaded only when software writes an exact two-byte key pair to the feed register. If the counter runs out, or a wrong key is written after the watchdog has been armed, the block asks the system for a reset. Once set, the control bits cannot be cleared by software. Only a system reset returns the block to its idle state.

Software first writes a timeout constant and sets the enable bit. It then writes the key pair. That first valid feed arms the watchdog. From then on, software has to repeat the key pair before the counter reaches zero. The live counter value is an output of the block and can also be read over the bus.

Top module: `feedlock_wdt`

## Requirements
- R1: After a synchronous reset, the counter holds 0xFF, the timeout constant reads 0xFF, the mode register (offset 0x0) reads 0 and the reset request is low.
- R2: While armed, the counter drops by exactly one every four clock cycles, and it stays at zero once it gets there.
- R3: While not armed, the counter keeps its value, whether or not the enable bit is set.
- R4: Writing 0xAA to the feed register (offset 0x8) and then 0x55 to it in the very next cycle loads the counter with the timeout constant. The new value is visible in the cycle after the 0x55 write.
- R5: A write to offset 0x4 stores bits 23:0 as the timeout constant. A value below 0xFF is stored as 0xFF.
- R6: In the mode register, bit 0 is enable and bit 1 is reset-select. Writing a 1 sets a bit. Writing a 0 has no effect, and only reset clears either bit.
- R7: Setting enable does not arm the watchdog. It becomes armed when a valid feed completes while enable is already set. The armed state reads back as mode bit 2.
- R8: When the armed counter steps from one to zero with reset-select set, the reset request is high for exactly one cycle, in the same cycle the counter first shows zero. With reset-select clear, no request is made.
- R9: Mode bit 3 is a sticky flag. It is set by an armed expiry or by a wrong feed while armed, and only reset clears it.
- R10: While armed, a wrong feed byte (a first byte other than 0xAA, or a second byte other than 0x55) raises the reset request in the cycle after that write. The reset-select bit does not matter here. While unarmed, a wrong byte only restarts the sequence.
- R11: Any other bus access between 0xAA and 0x55 aborts the sequence, so the following 0x55 does not reload the counter.
- R12: A read of offset 0xC returns the counter value, zero-extended, as it was in the read cycle. Read data for any register appears in the cycle after the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the bus and the watchdog |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| wdt_reset_req | output | 1 | One-cycle reset request |
| count_value | output | 24 | Live counter value |

## Verification
A behavioural model in the bench is compared against the counter, the reset request and the read data on every clock.

The feed path is tried with several patterns:
- a clean key pair;
- a key pair broken by a read;
- a key pair broken by a write to another register;
- a doubled first key after a good pair.

Between them, these separate a reload from an abort and from a reset-causing error. Expiry is run twice, once with reset-select set and once with it clear, which separates the sticky flag from the pulse. Software writes of zero to the mode bits, and writes below the floor of the timeout constant, show that those controls are one-way and clamped.

// File: rtl/fw_pkg.sv
// Shared constants for the key-fed watchdog: register offsets and the
// feed sequencer state type. Assumes a 4-bit byte-offset bus address.
package fw_pkg;
    localparam int ADDR_W = 4;
    localparam logic [ADDR_W-1:0] OFS_MODE  = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_TIME  = 4'h4;
    localparam logic [ADDR_W-1:0] OFS_FEED  = 4'h8;
    localparam logic [ADDR_W-1:0] OFS_COUNT = 4'hC;

    typedef enum logic {
        SEQ_IDLE   = 1'b0,
        SEQ_HAVE_A = 1'b1
    } feed_state_t;
endpackage

// File: rtl/fw_prescaler.sv
// Fixed-ratio clock-enable generator. Emits a one-cycle tick every DIV
// clocks. Free running from reset; assumes DIV >= 1.
module fw_prescaler #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

    generate
        if (DIV == 1) begin : g_nodiv
            logic unused_clk;
            assign unused_clk = clk ^ rst_n;
            assign tick = 1'b1;
        end else begin : g_div
            logic [PW-1:0] phase_q;
            localparam logic [PW-1:0] LAST = PW'(DIV - 1);

            // Cycle through DIV phases, wrapping on the last one
            always_ff @(posedge clk) begin
                if (!rst_n)
                    phase_q <= '0;
                else if (phase_q == LAST)
                    phase_q <= '0;
                else
                    phase_q <= phase_q + 1'b1;
            end

            assign tick = (phase_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/fw_feed_seq.sv
// Two-key feed recogniser. Reports a completed pair (reload) or a wrong
// key byte (bad) in the cycle of the offending write. Any other bus
// access between the keys silently drops back to idle. Assumes one bus
// access per cycle at most.
module fw_feed_seq #(
    parameter int           KEY_W = 8,
    parameter logic [7:0]   KEY_A = 8'hAA,
    parameter logic [7:0]   KEY_B = 8'h55
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             any_access,
    input  logic             feed_write,
    input  logic [KEY_W-1:0] feed_byte,
    output logic             reload,
    output logic             bad
);
    import fw_pkg::*;

    feed_state_t state_q, state_d;

    // Decide next state and the reload/bad strobes from this cycle's access
    always_comb begin
        state_d = state_q;
        reload  = 1'b0;
        bad     = 1'b0;
        if (feed_write) begin
            if (state_q == SEQ_IDLE) begin
                if (feed_byte == KEY_W'(KEY_A)) state_d = SEQ_HAVE_A;
                else                            bad     = 1'b1;
            end else begin
                state_d = SEQ_IDLE;
                if (feed_byte == KEY_W'(KEY_B)) reload = 1'b1;
                else                            bad    = 1'b1;
            end
        end else if (any_access) begin
            state_d = SEQ_IDLE;
        end
    end

    // Hold the sequencer state
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/fw_downcounter.sv
// Loadable down-counter that steps on prescaler ticks while running and
// saturates at zero. Flags the step from one to zero. Load wins over step.
module fw_downcounter #(
    parameter int CNT_W  = 24,
    parameter int TC_MIN = 255
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             hit_zero
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             step;

    assign step     = run && tick && !load && (cnt_q != '0);
    assign hit_zero = step && (cnt_q == ONE);
    assign cnt      = cnt_q;

    // Reload, step or hold the count
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= CNT_W'(TC_MIN);
        else if (load) cnt_q <= load_val;
        else if (step) cnt_q <= cnt_q - 1'b1;
    end
endmodule

// File: rtl/fw_ctrl_regs.sv
// Register file and policy for the watchdog: one-way mode bits, the
// clamped timeout constant, the arm latch, the sticky event flag, the
// reset request pulse and the registered read mux.
module fw_ctrl_regs #(
    parameter int CNT_W  = 24,
    parameter int DATA_W = 32,
    parameter int TC_MIN = 255
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_sel,
    input  logic                      bus_wr,
    input  logic [fw_pkg::ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0]         bus_wdata,
    input  logic                      reload,
    input  logic                      bad,
    input  logic                      timeout,
    input  logic [CNT_W-1:0]          cnt,
    output logic                      mode_en,
    output logic                      mode_rs,
    output logic                      armed,
    output logic [CNT_W-1:0]          tconst,
    output logic                      reset_req,
    output logic [DATA_W-1:0]         rdata
);
    import fw_pkg::*;

    localparam logic [CNT_W-1:0] TC_FLOOR = CNT_W'(TC_MIN);

    logic en_q, rs_q, armed_q, flag_q, req_q;
    logic [CNT_W-1:0]  tc_q;
    logic [DATA_W-1:0] rdata_q;
    logic              wr_mode, wr_time, rd_any, fault;
    logic [DATA_W-1:0] rd_mux;
    logic              unused_hi;

    assign unused_hi = ^bus_wdata[DATA_W-1:CNT_W];
    assign wr_mode   = bus_sel && bus_wr && (bus_addr == OFS_MODE);
    assign wr_time   = bus_sel && bus_wr && (bus_addr == OFS_TIME);
    assign rd_any    = bus_sel && !bus_wr;
    assign fault     = bad && armed_q;

    // Mode bits: set-only, cleared by reset alone
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
            rs_q <= 1'b0;
        end else if (wr_mode) begin
            en_q <= en_q | bus_wdata[0];
            rs_q <= rs_q | bus_wdata[1];
        end
    end

    // Timeout constant with floor clamp
    always_ff @(posedge clk) begin
        if (!rst_n)
            tc_q <= TC_FLOOR;
        else if (wr_time)
            tc_q <= (bus_wdata[CNT_W-1:0] < TC_FLOOR) ? TC_FLOOR
                                                       : bus_wdata[CNT_W-1:0];
    end

    // Arm on the first good feed seen with enable already set
    always_ff @(posedge clk) begin
        if (!rst_n)                armed_q <= 1'b0;
        else if (reload && en_q)   armed_q <= 1'b1;
    end

    // Sticky event flag and one-cycle reset request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            req_q  <= 1'b0;
        end else begin
            flag_q <= flag_q | timeout | fault;
            req_q  <= (timeout && rs_q) || fault;
        end
    end

    // Read mux over current register state
    always_comb begin
        unique case (bus_addr)
            OFS_MODE:  rd_mux = {{(DATA_W-4){1'b0}}, flag_q, armed_q, rs_q, en_q};
            OFS_TIME:  rd_mux = {{(DATA_W-CNT_W){1'b0}}, tc_q};
            OFS_COUNT: rd_mux = {{(DATA_W-CNT_W){1'b0}}, cnt};
            default:   rd_mux = '0;
        endcase
    end

    // Capture read data one cycle after the read access
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (rd_any) rdata_q <= rd_mux;
    end

    assign mode_en   = en_q;
    assign mode_rs   = rs_q;
    assign armed     = armed_q;
    assign tconst    = tc_q;
    assign reset_req = req_q;
    assign rdata     = rdata_q;
endmodule

// File: rtl/feedlock_wdt.sv
// Top of the key-fed watchdog. Single clock domain: bus and counter share
// clk, so the counter read path needs no synchroniser.
module feedlock_wdt #(
    parameter int         CNT_W  = 24,
    parameter int         DATA_W = 32,
    parameter int         DIV    = 4,
    parameter int         TC_MIN = 255,
    parameter logic [7:0] KEY_A  = 8'hAA,
    parameter logic [7:0] KEY_B  = 8'h55
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [3:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              wdt_reset_req,
    output logic [CNT_W-1:0]  count_value
);
    import fw_pkg::*;

    logic tick, reload, bad, timeout;
    logic mode_en, mode_rs, armed;
    logic [CNT_W-1:0] tconst, cnt;
    logic feed_write;

    assign feed_write = bus_sel && bus_wr && (bus_addr == OFS_FEED);

    fw_prescaler #(.DIV(DIV)) u_pre (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    fw_feed_seq #(.KEY_W(8), .KEY_A(KEY_A), .KEY_B(KEY_B)) u_seq (
        .clk(clk), .rst_n(rst_n), .any_access(bus_sel),
        .feed_write(feed_write), .feed_byte(bus_wdata[7:0]),
        .reload(reload), .bad(bad)
    );

    fw_downcounter #(.CNT_W(CNT_W), .TC_MIN(TC_MIN)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(armed), .tick(tick),
        .load(reload), .load_val(tconst), .cnt(cnt), .hit_zero(timeout)
    );

    fw_ctrl_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .TC_MIN(TC_MIN)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .reload(reload),
        .bad(bad), .timeout(timeout), .cnt(cnt), .mode_en(mode_en),
        .mode_rs(mode_rs), .armed(armed), .tconst(tconst),
        .reset_req(wdt_reset_req), .rdata(bus_rdata)
    );

    assign count_value = cnt;
endmodule

// File: rtl/fw_checker.sv
// Temporal checks for feedlock_wdt, attached by bind. Observes control
// state and strobes that separate submodules drive.
module fw_checker #(
    parameter int CNT_W  = 24,
    parameter int TC_MIN = 255
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_en,
    input logic             armed,
    input logic             mode_rs,
    input logic             tick,
    input logic             reload,
    input logic             bad,
    input logic             timeout,
    input logic             req,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] tconst
);
    // R6
    enable_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_en |=> mode_en);
    // R7
    armed_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed |=> armed);
    // R7
    arm_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> mode_en);
    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !reload) |=> $stable(cnt));
    // R2
    tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && tick && !reload && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
    // R5
    tconst_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tconst >= CNT_W'(TC_MIN));
    // R8
    expiry_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout && mode_rs) |=> req);
    // R10
    bad_feed_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bad && armed) |=> req);
endmodule

bind feedlock_wdt fw_checker #(.CNT_W(CNT_W), .TC_MIN(TC_MIN)) u_fw_checker (
    .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .armed(armed),
    .mode_rs(mode_rs), .tick(tick), .reload(reload), .bad(bad),
    .timeout(timeout), .req(wdt_reset_req), .cnt(cnt), .tconst(tconst)
);

// File: tb/feedlock_wdt_bench.sv
module feedlock_wdt_bench;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wdt_reset_req;
    logic [23:0] count_value;

    int checks = 0, errors = 0, pulses = 0, wide = 0;
    bit cmp_en = 0, done = 0, prev_req = 0;

    // behavioural reference state
    int m_cnt = 255, m_tc = 255, m_pre = 0, m_seq = 0;
    bit m_en = 0, m_rs = 0, m_armed = 0, m_flag = 0, m_req = 0;
    int m_rdata = 0;

    feedlock_wdt u_feedlock_wdt (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wdt_reset_req(wdt_reset_req), .count_value(count_value)
    );

    always #(CLK_P/2) clk = ~clk;

    always @(posedge clk) begin
        bit reload, bad, tick, nreq;
        int d;
        if (!rst_n) begin
            m_cnt = 255; m_tc = 255; m_pre = 0; m_seq = 0; m_rdata = 0;
            m_en = 0; m_rs = 0; m_armed = 0; m_flag = 0; m_req = 0;
        end else begin
            reload = 0; bad = 0; nreq = 0;
            d = int'(bus_wdata);
            if (bus_sel && !bus_wr) begin
                case (bus_addr)
                    4'h0: m_rdata = {m_flag, m_armed, m_rs, m_en};
                    4'h4: m_rdata = m_tc;
                    4'hC: m_rdata = m_cnt;
                    default: m_rdata = 0;
                endcase
            end
            if (bus_sel && bus_wr && bus_addr == 4'h8) begin
                if (m_seq == 0) begin
                    if ((d & 255) == 'hAA) m_seq = 1; else bad = 1;
                end else begin
                    m_seq = 0;
                    if ((d & 255) == 'h55) reload = 1; else bad = 1;
                end
            end else if (bus_sel) m_seq = 0;
            tick = (m_pre == 3);
            m_pre = (m_pre + 1) % 4;
            if (reload) begin
                m_cnt = m_tc;
                if (m_en) m_armed = 1;
            end else if (m_armed && tick && m_cnt > 0) begin
                m_cnt = m_cnt - 1;
                if (m_cnt == 0) begin
                    m_flag = 1;
                    if (m_rs) nreq = 1;
                end
            end
            if (bad && m_armed) begin nreq = 1; m_flag = 1; end
            if (bus_sel && bus_wr && bus_addr == 4'h0) begin
                m_en = m_en | d[0]; m_rs = m_rs | d[1];
            end
            if (bus_sel && bus_wr && bus_addr == 4'h4)
                m_tc = ((d & 'hFFFFFF) < 255) ? 255 : (d & 'hFFFFFF);
            m_req = nreq;
        end
    end

    // per-clock comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (cmp_en) begin
            checks += 3;
            if (count_value !== 24'(m_cnt)) begin
                errors++; $display("FAIL R2 count: actual %h expected %h", count_value, m_cnt);
            end
            if (wdt_reset_req !== m_req) begin
                errors++; $display("FAIL R8 reset request: actual %b expected %b", wdt_reset_req, m_req);
            end
            if (bus_rdata !== 32'(m_rdata)) begin
                errors++; $display("FAIL R12 read data: actual %h expected %h", bus_rdata, m_rdata);
            end
            if (wdt_reset_req) pulses++;
            if (wdt_reset_req && prev_req) wide++;
            prev_req = wdt_reset_req;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic w, input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = w; bus_addr = a; bus_wdata = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bus_sel = 1'b0; bus_wr = 1'b0;
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        drive(1'b0, a, 32'h0);
        idle(1);
        v = bus_rdata;
    endtask

    task automatic feed();
        drive(1'b1, 4'h8, 32'hAA);
        drive(1'b1, 4'h8, 32'h55);
        idle(1);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [23:0] c0, c1;
        int p0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp_en = 1;
        // R1 reset state
        chk("R1 count", 32'(count_value), 32'hFF);
        chk("R1 request", 32'(wdt_reset_req), 0);
        rd(4'h0, v); chk("R1 mode", v, 0);
        rd(4'h4, v); chk("R1 timeout", v, 32'hFF);
        // R5 clamp and width
        drive(1'b1, 4'h4, 32'h10); rd(4'h4, v); chk("R5 floor", v, 32'hFF);
        drive(1'b1, 4'h4, 32'hAB000300); rd(4'h4, v); chk("R5 low bits", v, 32'h300);
        idle(20); chk("R3 unarmed hold", 32'(count_value), 32'hFF);
        // R4 reload without enable; stays unarmed
        feed(); chk("R4 reload", 32'(count_value), 32'h300);
        rd(4'h0, v); chk("R7 not armed", v, 0);
        idle(40); chk("R3 hold after feed", 32'(count_value), 32'h300);
        // R11 aborted sequences
        drive(1'b1, 4'h4, 32'h400);
        drive(1'b1, 4'h8, 32'hAA); drive(1'b0, 4'h0, 0); drive(1'b1, 4'h8, 32'h55); idle(1);
        chk("R11 read abort", 32'(count_value), 32'h300);
        chk("R10 unarmed bad", 32'(wdt_reset_req), 0);
        drive(1'b1, 4'h8, 32'hAA); drive(1'b1, 4'h4, 32'h400); drive(1'b1, 4'h8, 32'h55); idle(1);
        chk("R11 write abort", 32'(count_value), 32'h300);
        // R6 / R7 enable alone does not arm; zero writes ignored
        drive(1'b1, 4'h0, 32'h1); rd(4'h0, v); chk("R7 enable only", v, 32'h1);
        drive(1'b1, 4'h0, 32'h0); rd(4'h0, v); chk("R6 zero ignored", v, 32'h1);
        idle(20); chk("R3 enabled hold", 32'(count_value), 32'h300);
        feed(); chk("R4 reload armed", 32'(count_value), 32'h400);
        rd(4'h0, v); chk("R7 armed", v, 32'h5);
        // R2 rate
        c0 = count_value; idle(40); c1 = count_value;
        chk("R2 rate", 32'(c0 - c1), 32'd10);
        // R12 counter readback
        drive(1'b0, 4'hC, 0); c0 = count_value; idle(1);
        chk("R12 count read", bus_rdata, 32'(c0));
        // R8 expiry with reset-select
        drive(1'b1, 4'h4, 32'h100); drive(1'b1, 4'h0, 32'h2);
        rd(4'h0, v); chk("R6 reset-select", v, 32'h7);
        feed(); p0 = pulses;
        idle(1100);
        chk("R8 one pulse", 32'(pulses - p0), 1);
        chk("R8 pulse width", 32'(wide), 0);
        chk("R2 saturate", 32'(count_value), 0);
        rd(4'h0, v); chk("R9 flag", v, 32'hF);
        // R10 bad feed after a good pair
        p0 = pulses;
        drive(1'b1, 4'h8, 32'hAA); drive(1'b1, 4'h8, 32'h55);
        drive(1'b1, 4'h8, 32'hAA); drive(1'b1, 4'h8, 32'hAA); idle(1);
        chk("R10 request", 32'(wdt_reset_req), 1);
        idle(1);
        chk("R10 single", 32'(wdt_reset_req), 0);
        chk("R10 count", 32'(pulses - p0), 1);
        // R9 / R6 cleared only by reset
        @(negedge clk); rst_n = 1'b0; idle(2); rst_n = 1'b1;
        rd(4'h0, v); chk("R9 reset clears", v, 0);
        // R8 expiry without reset-select
        drive(1'b1, 4'h4, 32'h100); drive(1'b1, 4'h0, 32'h1); feed();
        p0 = pulses; idle(1100);
        chk("R8 no select no pulse", 32'(pulses - p0), 0);
        rd(4'h0, v); chk("R9 flag no select", v, 32'hD);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule